// File: doc/BRIEF.md
# Peripheral Reset Register Controller

This block holds the reset lines for up to ninety-six peripherals in three 32-bit registers. A set bit keeps its peripheral in reset. Software reaches the registers through a plain 32-bit register bus: address, write enable, write data and combinational read data. A whole register is replaced by a bus write.

A second port carries single-line requests. Each request holds a packed identifier and an operation: set one line, clear one line, or report one line's state. The identifier carries the register offset in its upper byte and the bit index in its low five bits. It is checked before any register is touched, and a bad identifier is answered with an error flag and changes nothing. A bus write in the same cycle as a line request wins. The request waits in a one-entry slot and runs on the next cycle that has no bus write.

A separate software-reset word asks for a whole-system reset from one of four sources. Writing a single bit to it, shifted by the source number, gives a one-cycle request pulse on the matching output. Any other value does nothing.

Top module: `prst_ctrl`

## Requirements
- R1: After the asynchronous reset, all three reset registers are zero, `periph_rst`, `sys_rst_req`, `line_done`, `line_err` and `line_stat` are low, and every register reads back zero.
- R2: A bus write to byte offset 0x20, 0x24 or 0x34 replaces that whole register. The register then reads back the written value. Its bits appear on `periph_rst[31:0]` for 0x20, `periph_rst[63:32]` for 0x24 and `periph_rst[95:64]` for 0x34.
- R3: Reads of any other offset, including the software-reset word at 0x14, return zero. Bus writes to offsets other than the three reset registers and 0x14 change no register.
- R4: `line_id` is decoded as offset = `line_id[15:8]` and bit index = `line_id[4:0]`. Bits `line_id[7:5]` must be zero. `line_op` encodes 2'b01 set, 2'b10 clear and 2'b11 status. A request with 2'b00 is ignored and gives no `line_done`.
- R5: A set request makes the addressed bit one and leaves every other bit of that register unchanged.
- R6: A clear request makes the addressed bit zero and leaves every other bit of that register unchanged.
- R7: A status request returns the addressed bit on `line_stat` and changes no register.
- R8: A request whose offset is not 0x20, 0x24 or 0x34, or whose `line_id[7:5]` is not zero (bit index 32 or more), gives `line_done` and `line_err` together and changes no register.
- R9: A request that meets no pending request and no bus write runs at the clock edge that samples it. `line_done` and its `line_err` and `line_stat` are high for exactly the following cycle.
- R10: When a bus write and a request arrive in the same cycle, the bus write lands first. The request is held and runs at the first later edge without a bus write, so it acts on the written value. A new request that arrives while one is held is ignored.
- R11: A bus write to 0x14 of 0x4 shifted left by n, for n from 1 to 4, drives `sys_rst_req[n-1]` high for exactly the cycle after the write edge. At most one request bit is ever high.
- R12: A write to 0x14 of any other value, such as 0x4, 0x0, 0x18 or 0x80, raises no `sys_rst_req` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_req | input | 1 | Single-line request valid |
| line_op | input | 2 | Request operation: 01 set, 10 clear, 11 status, 00 none |
| line_id | input | 16 | Packed reset identifier |
| line_done | output | 1 | Request completed (one cycle) |
| line_err | output | 1 | Completed request had an invalid identifier |
| line_stat | output | 1 | Bit value returned by a status request |
| periph_rst | output | 96 | Active-high peripheral reset lines |
| sys_rst_req | output | 4 | One-cycle system-reset requests, bit n-1 for source n |

## Verification
The bench first loads known patterns by bus write and then walks single-line set, clear and status requests across all three registers. It covers the lowest and highest bit index and registers that already hold mixed ones and zeros. These patterns show whether a line operation keeps the other 31 bits and whether the offset is routed to the right register. Two kinds of bad identifier are sent, an unmapped offset and an index of 32, to separate the two validity checks. A write and a request are then made to collide on the same register, with a second request sent while the first one waits. This shows whether the write wins, whether the held request runs on the written value, and whether the extra request is dropped. The software-reset word gets every valid source pattern, plus neighbour values that are off by one shift or carry two bits, to separate exact matching from loose decoding.

// File: rtl/prst_pkg.sv
package prst_pkg;

  localparam int ID_OFS_SHIFT = 8;
  localparam int NUM_BANKS    = 3;
  localparam int NUM_SRC      = 4;
  localparam logic [7:0]  SWR_OFS  = 8'h14;
  localparam logic [31:0] SWR_BASE = 32'h0000_0004;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_STAT = 2'b11
  } line_op_e;

  // byte offset of reset register bank i
  function automatic logic [7:0] bank_ofs(input int i);
    case (i)
      0:       bank_ofs = 8'h20;
      1:       bank_ofs = 8'h24;
      default: bank_ofs = 8'h34;
    endcase
  endfunction

endpackage

// File: rtl/prst_id_decode.sv
module prst_id_decode
  import prst_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [ID_W-1:0]      id,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [IDX_W-1:0]     bit_idx,
  output logic                 id_ok
);

  logic [ID_W-1:0] ofs_field;
  logic            idx_ok;

  assign ofs_field = id >> ID_OFS_SHIFT;
  assign bit_idx   = id[IDX_W-1:0];
  assign idx_ok    = (id[ID_OFS_SHIFT-1:0] >> IDX_W) == '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (ofs_field == ID_W'(bank_ofs(b)));
  end

  assign id_ok = idx_ok && (|bank_hit);

endmodule

// File: rtl/prst_bank.sv
module prst_bank #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ln_en,
  input  logic              ln_set,
  input  logic [IDX_W-1:0]  ln_idx,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_nxt;
  logic              q_upd;

  assign q_upd = wr_en | ln_en;

  always_comb begin
    q_nxt = q;
    if (wr_en) begin
      q_nxt = wr_data;
    end else if (ln_en) begin
      q_nxt[ln_idx] = ln_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_upd) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/prst_swreset.sv
module prst_swreset
  import prst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] pulse
);

  logic [NUM_SRC-1:0] match;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign match[s] = wr_hit && (wr_data == (DATA_W'(SWR_BASE) << (s + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= '0;
    end else begin
      pulse <= match;
    end
  end

endmodule

// File: rtl/prst_line_sched.sv
module prst_line_sched
  import prst_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  line_op_e        req_op,
  input  logic [ID_W-1:0] req_id,
  input  logic            bus_busy,
  output logic            exec,
  output line_op_e        exec_op,
  output logic [ID_W-1:0] exec_id
);

  logic            pend_v, pend_v_nxt;
  line_op_e        pend_op;
  logic [ID_W-1:0] pend_id;
  logic            accept;

  assign accept  = req && (req_op != OP_NOP) && !pend_v;
  assign exec    = (pend_v || accept) && !bus_busy;
  assign exec_op = pend_v ? pend_op : req_op;
  assign exec_id = pend_v ? pend_id : req_id;

  always_comb begin
    pend_v_nxt = pend_v;
    if (exec) begin
      pend_v_nxt = 1'b0;
    end else if (accept) begin
      pend_v_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
    end else begin
      pend_v <= pend_v_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op <= OP_NOP;
      pend_id <= '0;
    end else if (accept) begin
      pend_op <= req_op;
      pend_id <= req_id;
    end
  end

endmodule

// File: rtl/prst_ctrl.sv
module prst_ctrl
  import prst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int RST_W = NUM_BANKS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               line_req,
  input  logic [1:0]         line_op,
  input  logic [ID_W-1:0]    line_id,
  output logic               line_done,
  output logic               line_err,
  output logic               line_stat,
  output logic [RST_W-1:0]   periph_rst,
  output logic [NUM_SRC-1:0] sys_rst_req
);

  logic                 exec;
  line_op_e             exec_op;
  logic [ID_W-1:0]      exec_id;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [IDX_W-1:0]     bit_idx;
  logic                 id_ok;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_rd;
  logic [NUM_BANKS-1:0] bank_bit;
  logic                 sel_bit;
  logic                 done_nxt, err_nxt, stat_nxt;

  prst_line_sched #(.ID_W(ID_W)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (line_req),
    .req_op   (line_op_e'(line_op)),
    .req_id   (line_id),
    .bus_busy (bus_we),
    .exec     (exec),
    .exec_op  (exec_op),
    .exec_id  (exec_id)
  );

  prst_id_decode #(.ID_W(ID_W), .DATA_W(DATA_W)) u_dec (
    .id       (exec_id),
    .bank_hit (bank_hit),
    .bit_idx  (bit_idx),
    .id_ok    (id_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_hit;
    logic ln_hit;

    assign wr_hit = bus_we && (bus_addr == ADDR_W'(bank_ofs(b)));
    assign ln_hit = exec && id_ok && bank_hit[b] && (exec_op != OP_STAT);

    prst_bank #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .wr_data (bus_wdata),
      .ln_en   (ln_hit),
      .ln_set  (exec_op == OP_SET),
      .ln_idx  (bit_idx),
      .q       (bank_q[b])
    );

    assign periph_rst[b*DATA_W +: DATA_W] = bank_q[b];
    assign bank_rd[b]  = (bus_addr == ADDR_W'(bank_ofs(b)));
    assign bank_bit[b] = bank_hit[b] && bank_q[b][bit_idx];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_rd[b]) begin
        bus_rdata = bank_q[b];
      end
    end
  end

  assign sel_bit = |bank_bit;

  prst_swreset #(.DATA_W(DATA_W)) u_swr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (bus_we && (bus_addr == ADDR_W'(SWR_OFS))),
    .wr_data (bus_wdata),
    .pulse   (sys_rst_req)
  );

  always_comb begin
    done_nxt = exec;
    err_nxt  = exec && !id_ok;
    stat_nxt = exec && id_ok && (exec_op == OP_STAT) && sel_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_done <= 1'b0;
      line_err  <= 1'b0;
      line_stat <= 1'b0;
    end else begin
      line_done <= done_nxt;
      line_err  <= err_nxt;
      line_stat <= stat_nxt;
    end
  end

endmodule

// File: rtl/prst_ctrl_chk.sv
module prst_ctrl_chk
  import prst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int RST_W = NUM_BANKS * DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               line_done,
  input logic               line_err,
  input logic               line_stat,
  input logic [RST_W-1:0]   periph_rst,
  input logic [NUM_SRC-1:0] sys_rst_req
);

  // R11
  swr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sys_rst_req));

  // R11
  swr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req != '0) |-> $past(bus_we && (bus_addr == ADDR_W'(SWR_OFS))));

  // R8
  bad_id_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> (periph_rst == $past(periph_rst)));

  // R8
  err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> line_done);

  // R7
  stat_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat |-> (line_done && !line_err));

  // R10
  no_exec_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !$past(bus_we));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
    // R2
    bus_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == ADDR_W'(bank_ofs(b))))
        |=> (periph_rst[b*DATA_W +: DATA_W] == $past(bus_wdata)));
  end

endmodule

bind prst_ctrl prst_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .line_done   (line_done),
  .line_err    (line_err),
  .line_stat   (line_stat),
  .periph_rst  (periph_rst),
  .sys_rst_req (sys_rst_req)
);

// File: tb/prst_ctrl_tb.sv
module prst_ctrl_tb;
  import prst_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  localparam logic [1:0] K_WR = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam logic [1:0] K_LN = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  op;
    logic [15:0] addr;   // bus offset or line identifier
    logic [31:0] data;
    logic [31:0] exp;    // read value, or {err,stat} for line requests
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{K_WR, 2'b00, 16'h0020, 32'h0000_00FF, 32'h0,          4'd2},  // R2
    '{K_RD, 2'b00, 16'h0020, 32'h0,          32'h0000_00FF, 4'd2},  // R2
    '{K_LN, 2'b01, 16'h2008, 32'h0,          32'h0,          4'd5},  // R5
    '{K_RD, 2'b00, 16'h0020, 32'h0,          32'h0000_01FF, 4'd5},  // R5
    '{K_LN, 2'b10, 16'h2000, 32'h0,          32'h0,          4'd6},  // R6
    '{K_RD, 2'b00, 16'h0020, 32'h0,          32'h0000_01FE, 4'd6},  // R6
    '{K_LN, 2'b11, 16'h2001, 32'h0,          32'h1,          4'd7},  // R7
    '{K_LN, 2'b11, 16'h2000, 32'h0,          32'h0,          4'd7},  // R7
    '{K_LN, 2'b01, 16'h341F, 32'h0,          32'h0,          4'd4},  // R4
    '{K_RD, 2'b00, 16'h0034, 32'h0,          32'h8000_0000, 4'd4},  // R4
    '{K_LN, 2'b01, 16'h2420, 32'h0,          32'h2,          4'd8},  // R8
    '{K_LN, 2'b01, 16'h3005, 32'h0,          32'h2,          4'd8},  // R8
    '{K_RD, 2'b00, 16'h0024, 32'h0,          32'h0,          4'd8},  // R8
    '{K_RD, 2'b00, 16'h0030, 32'h0,          32'h0,          4'd3},  // R3
    '{K_WR, 2'b00, 16'h0024, 32'hA5A5_A5A5, 32'h0,          4'd2},  // R2
    '{K_LN, 2'b10, 16'h2400, 32'h0,          32'h0,          4'd6},  // R6
    '{K_RD, 2'b00, 16'h0024, 32'h0,          32'hA5A5_A5A4, 4'd6},  // R6
    '{K_RD, 2'b00, 16'h0014, 32'h0,          32'h0,          4'd3},  // R3
    '{K_LN, 2'b11, 16'h241F, 32'h0,          32'h1,          4'd7}   // R7
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        line_req;
  logic [1:0]  line_op;
  logic [15:0] line_id;
  logic        line_done, line_err, line_stat;
  logic [95:0] periph_rst;
  logic [3:0]  sys_rst_req;

  int n_chk;
  int n_bad;
  bit finished;

  prst_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .line_req    (line_req),
    .line_op     (line_op),
    .line_id     (line_id),
    .line_done   (line_done),
    .line_err    (line_err),
    .line_stat   (line_stat),
    .periph_rst  (periph_rst),
    .sys_rst_req (sys_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic line_cmd(input logic [1:0] op, input logic [15:0] id);
    @(negedge clk);
    line_req = 1'b1;
    line_op  = op;
    line_id  = id;
    @(negedge clk);
    line_req = 1'b0;
    line_op  = 2'b00;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    bus_addr = '0;
    bus_we = 1'b0;
    bus_wdata = '0;
    line_req = 1'b0;
    line_op = 2'b00;
    line_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(periph_rst == '0, "R1 lines", periph_rst, '0);
    check({sys_rst_req, line_done, line_err, line_stat} == '0, "R1 flags",
          {sys_rst_req, line_done, line_err, line_stat}, '0);
    for (int b = 0; b < NUM_BANKS; b++) begin
      bus_read(bank_ofs(b), rd);
      check(rd == '0, "R1 readback", rd, '0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_WR: bus_write(VECS[i].addr[7:0], VECS[i].data);
        K_RD: begin
          bus_read(VECS[i].addr[7:0], rd);
          check(rd == VECS[i].exp, $sformatf("R%0d read vec %0d", VECS[i].req, i),
                rd, VECS[i].exp);
        end
        default: begin
          line_cmd(VECS[i].op, VECS[i].addr);
          check({line_done, line_err, line_stat} == {1'b1, VECS[i].exp[1:0]},
                $sformatf("R%0d line vec %0d", VECS[i].req, i),
                {line_done, line_err, line_stat}, {1'b1, VECS[i].exp[1:0]});
        end
      endcase
    end
    // R2 line ordering on the output vector
    check(periph_rst == {32'h8000_0000, 32'hA5A5_A5A4, 32'h0000_01FE}, "R2 map",
          periph_rst, {32'h8000_0000, 32'hA5A5_A5A4, 32'h0000_01FE});

    // R9 done lasts one cycle
    line_cmd(2'b11, 16'h2001);
    @(negedge clk);
    check(line_done == 1'b0, "R9 single pulse", line_done, 1'b0);

    // R4 op 00 ignored
    line_cmd(2'b00, 16'h2002);
    check(line_done == 1'b0, "R4 nop done", line_done, 1'b0);
    check(periph_rst[31:0] == 32'h0000_01FE, "R4 nop keep", periph_rst[31:0], 32'h1FE);

    // R3 unmapped write changes nothing
    bus_write(8'h28, 32'hFFFF_FFFF);
    check(periph_rst == {32'h8000_0000, 32'hA5A5_A5A4, 32'h0000_01FE}, "R3 unmapped write",
          periph_rst, {32'h8000_0000, 32'hA5A5_A5A4, 32'h0000_01FE});
    bus_read(8'h28, rd);
    check(rd == '0, "R3 unmapped read", rd, '0);

    // R10 collision: write wins, held request runs after, extra request dropped
    @(negedge clk);
    bus_addr = 8'h24; bus_wdata = 32'hF0F0_0000; bus_we = 1'b1;
    line_req = 1'b1; line_op = 2'b01; line_id = 16'h2403;
    @(negedge clk);
    line_id = 16'h2404;
    @(negedge clk);
    bus_we = 1'b0; line_req = 1'b0; line_op = 2'b00;
    check(line_done == 1'b0, "R10 held during write", line_done, 1'b0);
    check(periph_rst[63:32] == 32'hF0F0_0000, "R10 write first", periph_rst[63:32],
          32'hF0F0_0000);
    @(negedge clk);
    check(line_done == 1'b1 && line_err == 1'b0, "R10 held done", line_done, 1'b1);
    check(periph_rst[63:32] == 32'hF0F0_0008, "R10 held applied", periph_rst[63:32],
          32'hF0F0_0008);
    @(negedge clk);
    check(line_done == 1'b0, "R10 extra dropped", line_done, 1'b0);

    // R11 every valid source
    for (int n = 1; n <= NUM_SRC; n++) begin
      bus_write(8'h14, 32'h4 << n);
      check(sys_rst_req == 4'(1 << (n - 1)), "R11 pulse", sys_rst_req, 4'(1 << (n - 1)));
      @(negedge clk);
      check(sys_rst_req == '0, "R11 pulse end", sys_rst_req, '0);
    end

    // R12 other values ignored
    bus_write(8'h14, 32'h4);
    check(sys_rst_req == '0, "R12 base", sys_rst_req, '0);
    bus_write(8'h14, 32'h0);
    check(sys_rst_req == '0, "R12 zero", sys_rst_req, '0);
    bus_write(8'h14, 32'h18);
    check(sys_rst_req == '0, "R12 two bits", sys_rst_req, '0);
    bus_write(8'h14, 32'h80);
    check(sys_rst_req == '0, "R12 past range", sys_rst_req, '0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule